// File: doc/BRIEF.md
# Instruction Fetch Execution Monitor

This block sits between instruction memory and a simple 32-bit CPU. It looks at the address of every instruction fetch. When the address lies in a region where code must not run, it replaces the word from memory with an all-zero word. All zeros is an illegal RV32 encoding, so the CPU traps on it. Data loads and stores pass through unchanged.

There are two forbidden regions. The first is a fixed 2 KiB firmware scratch window in the memory-mapped space, and fetches from it are always blocked. The second region is programmable. Software writes a low bound and a high bound through a small register write port, then sets an arm bit in a control register. The arm bit is a one-way switch that only reset clears. Once it is set, the bounds are frozen and the range check is enforced.

The arming logic is a two-state machine. `ST_OPEN` is the state after reset: the bounds can be written and the range is not enforced. `ST_LOCKED`: the range is enforced and the bounds are read-only. There is one transition, `arm`, from `ST_OPEN` to `ST_LOCKED`. It is taken on a control write with bit 0 set. In `ST_LOCKED` the machine holds its state on every input.

The fetch path is combinational. The address and memory data are expected to be held stable together, as on a valid/ready memory bus. Register writes take effect at the next rising clock edge.

Top module: `exec_fetch_guard`

## Requirements
- R1: A fetch (`fetch_valid`=1) whose address is in no forbidden region returns `mem_rdata` unchanged on `cpu_rdata` in the same cycle.
- R2: A fetch from the fixed window returns 32'h0000_0000, whether or not the block is armed. The window covers addresses where bits [31:24] equal 8'hD0 and bits [23:11] are all zero, i.e. 0xD000_0000 to 0xD000_07FF.
- R3: Fetches just outside the fixed window pass unchanged, for example 0xD000_0800 and 0xCFFF_FFFC.
- R4: While unarmed (`ST_OPEN`), fetches inside the programmed range pass unchanged.
- R5: A write with `cfg_sel`=2'b00 (control) and `cfg_wdata[0]`=1 takes the `arm` transition at that edge. From then on, fetches with low <= address <= high (unsigned, both ends inclusive) return 32'h0. Addresses low-1 and high+1 pass.
- R6: If the low bound is greater than the high bound when armed, no address is blocked by the programmable range.
- R7: Once armed, the block stays armed until reset. A later control write with bit 0 = 0 does not disarm it.
- R8: While unarmed, `cfg_sel`=2'b01 writes the low bound and `cfg_sel`=2'b10 writes the high bound. While armed, writes to either bound are ignored.
- R9: A non-fetch access (`fetch_valid`=0) always passes `mem_rdata` unchanged, even at a forbidden address.
- R10: After reset the block is unarmed, so only the fixed window blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Current access is an instruction fetch |
| fetch_addr | input | 32 | Byte address of the current access |
| mem_rdata | input | 32 | Word returned by memory |
| cpu_rdata | output | 32 | Word delivered to the CPU |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 00 control, 01 low bound, 10 high bound |
| cfg_wdata | input | 32 | Register write data |

## Verification
Fetches are issued with a distinctive non-zero memory word, so a pass-through can always be told apart from a substitution. The tests cover:
- the fixed window at its edges and just beyond them, both before and after arming;
- the programmable range at low-1, low, high and high+1, both before and after arming;
- an inverted range, which separates a true two-sided comparison from a one-sided one;
- non-fetch accesses at blocked addresses, which show that only instruction fetches are filtered.

Bound rewrites and disarm attempts after arming are followed by fetches at addresses that would change outcome if the write had taken effect.

// File: rtl/exm_pkg.sv
package exm_pkg;
    localparam int unsigned XLEN = 32;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } arm_state_e;

    localparam logic [1:0] SEL_CTRL = 2'b00;
    localparam logic [1:0] SEL_LOW  = 2'b01;
    localparam logic [1:0] SEL_HIGH = 2'b10;

    localparam logic [XLEN-1:0] TRAP_WORD = '0;
endpackage

// File: rtl/exm_fw_window.sv
module exm_fw_window #(
    parameter int unsigned AW        = 32,
    parameter int unsigned SEL_BITS  = 8,
    parameter logic [7:0]  PREFIX    = 8'hD0,
    parameter int unsigned WIN_BYTES = 2048
) (
    input  logic [AW-1:0] addr,
    output logic          in_window
);
    localparam int unsigned OFS_BITS  = $clog2(WIN_BYTES);
    localparam int unsigned ZERO_HI   = AW - SEL_BITS - 1;
    localparam int unsigned ZERO_BITS = AW - SEL_BITS - OFS_BITS;

    logic prefix_hit;
    logic upper_zero;

    always_comb begin
        prefix_hit = (addr[AW-1 -: SEL_BITS] == PREFIX[SEL_BITS-1:0]);
        upper_zero = (addr[ZERO_HI -: ZERO_BITS] == '0);
        in_window  = prefix_hit && upper_zero;
    end
endmodule

// File: rtl/exm_region_ctl.sv
module exm_region_ctl
    import exm_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic [AW-1:0] addr,
    output logic          range_hit
);
    arm_state_e    state_q, state_d;
    logic [AW-1:0] low_q, high_q;
    logic          arm_req;

    assign arm_req = cfg_we && (cfg_sel == SEL_CTRL) && cfg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (arm_req) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
        end else if (state_q == ST_OPEN && cfg_we) begin
            if (cfg_sel == SEL_LOW)  low_q  <= cfg_wdata;
            if (cfg_sel == SEL_HIGH) high_q <= cfg_wdata;
        end
    end

    always_comb begin
        range_hit = 1'b0;
        unique case (state_q)
            ST_OPEN:   range_hit = 1'b0;
            ST_LOCKED: range_hit = (addr >= low_q) && (addr <= high_q);
            default:   range_hit = 1'b0;
        endcase
    end

    // R7: armed state holds until reset
    a_r7_sticky_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED));

    // R8: bounds frozen while armed
    a_r8_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> ($stable(low_q) && $stable(high_q)));

    // R5: arm request in open state arms at the edge
    a_r5_arm_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && arm_req) |=> (state_q == ST_LOCKED));

    // R6: inverted bounds never hit
    a_r6_inverted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q > high_q) |-> !range_hit);
endmodule

// File: rtl/exm_fetch_mux.sv
module exm_fetch_mux
    import exm_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          fetch_valid,
    input  logic          forbid,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] cpu_rdata
);
    always_comb begin
        if (fetch_valid && forbid) cpu_rdata = TRAP_WORD[DW-1:0];
        else                       cpu_rdata = mem_rdata;
    end
endmodule

// File: rtl/exec_fetch_guard.sv
module exec_fetch_guard
    import exm_pkg::*;
#(
    parameter int unsigned AW           = 32,
    parameter int unsigned DW           = 32,
    parameter logic [7:0]  FW_PREFIX    = 8'hD0,
    parameter int unsigned FW_WIN_BYTES = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata
);
    logic fw_hit;
    logic range_hit;
    logic forbid;

    exm_fw_window #(
        .AW(AW), .SEL_BITS(8), .PREFIX(FW_PREFIX), .WIN_BYTES(FW_WIN_BYTES)
    ) u_fw (
        .addr(fetch_addr), .in_window(fw_hit)
    );

    exm_region_ctl #(.AW(AW)) u_rgn (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .addr(fetch_addr), .range_hit(range_hit)
    );

    assign forbid = fw_hit || range_hit;

    exm_fetch_mux #(.DW(DW)) u_mux (
        .fetch_valid(fetch_valid), .forbid(forbid),
        .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata)
    );

    // R2: fixed window fetches always trap
    a_r2_fw_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fw_hit) |-> (cpu_rdata == '0));

    // R5: armed range hits trap
    a_r5_range_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && range_hit) |-> (cpu_rdata == '0));

    // R9: non-fetch traffic untouched
    a_r9_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> (cpu_rdata == mem_rdata));

    // R1: fetches outside every region untouched
    a_r1_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fw_hit && !range_hit) |-> (cpu_rdata == mem_rdata));
endmodule

// File: tb/sim_exec_fetch_guard.sv
module sim_exec_fetch_guard;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PAT = 32'hA5C3_0F13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] cpu_rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic [31:0] cfg_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_fetch_guard u0 (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; fetch_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string req, input logic fv, input logic [31:0] a, input bit trap);
        @(negedge clk);
        fetch_valid = fv; fetch_addr = a; mem_rdata = PAT ^ a;
        #1;
        check(req, cpu_rdata, trap ? 32'h0 : (PAT ^ a));
        fetch_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        probe("R10", 1'b1, 32'h0000_0000, 1'b0);
        probe("R10", 1'b1, 32'hD000_0004, 1'b1);
        probe("R1",  1'b1, 32'h4000_1000, 1'b0);
    endtask

    task automatic t_fixed_window();
        do_reset();
        probe("R2", 1'b1, 32'hD000_0000, 1'b1);
        probe("R2", 1'b1, 32'hD000_07FF, 1'b1);
        probe("R3", 1'b1, 32'hD000_0800, 1'b0);
        probe("R3", 1'b1, 32'hCFFF_FFFC, 1'b0);
        probe("R3", 1'b1, 32'hD100_0000, 1'b0);
        probe("R9", 1'b0, 32'hD000_0010, 1'b0);
    endtask

    task automatic t_range_arm();
        do_reset();
        wr(2'b01, 32'h4000_2000);
        wr(2'b10, 32'h4000_2FFF);
        probe("R4", 1'b1, 32'h4000_2000, 1'b0);
        probe("R4", 1'b1, 32'h4000_2800, 1'b0);
        wr(2'b00, 32'h0000_0001);
        probe("R5", 1'b1, 32'h4000_1FFF, 1'b0);
        probe("R5", 1'b1, 32'h4000_2000, 1'b1);
        probe("R5", 1'b1, 32'h4000_2800, 1'b1);
        probe("R5", 1'b1, 32'h4000_2FFF, 1'b1);
        probe("R5", 1'b1, 32'h4000_3000, 1'b0);
        probe("R9", 1'b0, 32'h4000_2800, 1'b0);
        probe("R2", 1'b1, 32'hD000_0100, 1'b1);
    endtask

    task automatic t_locked_writes();
        // continues from armed state of t_range_arm
        wr(2'b00, 32'h0000_0000);
        probe("R7", 1'b1, 32'h4000_2400, 1'b1);
        wr(2'b01, 32'h4000_2800);
        probe("R8", 1'b1, 32'h4000_2000, 1'b1);
        wr(2'b10, 32'h4000_5000);
        probe("R8", 1'b1, 32'h4000_3000, 1'b0);
        wr(2'b01, 32'hFFFF_FFFF);
        probe("R8", 1'b1, 32'h4000_2FFF, 1'b1);
    endtask

    task automatic t_inverted();
        do_reset();
        wr(2'b01, 32'h4000_3000);
        wr(2'b10, 32'h4000_1000);
        wr(2'b00, 32'hFFFF_FFFF);
        probe("R6", 1'b1, 32'h4000_1000, 1'b0);
        probe("R6", 1'b1, 32'h4000_2000, 1'b0);
        probe("R6", 1'b1, 32'h4000_3000, 1'b0);
        probe("R6", 1'b1, 32'h4000_0FFF, 1'b0);
    endtask

    task automatic t_reset_disarms();
        do_reset();
        wr(2'b01, 32'h0000_0000);
        wr(2'b10, 32'hFFFF_FFFF);
        wr(2'b00, 32'h0000_0001);
        probe("R5", 1'b1, 32'h1234_5678, 1'b1);
        do_reset();
        probe("R10", 1'b1, 32'h1234_5678, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_fixed_window();
        t_range_arm();
        t_locked_writes();
        t_inverted();
        t_reset_disarms();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule